// File: doc/BRIEF.md
# Single-Cycle Four-Bit Nanoprocessor Core

This block is a complete, very small processor that completes one instruction on every clock. Each instruction is fetched from an eight-entry program store of 12-bit words, decoded, executed and written back in the same cycle. The program store is a parameter. Its default contents add the integers one, two and three, copy the total into the display register, and then park the core on a self-jump.

The core has eight 4-bit registers. Register 0 is hard-wired to zero. Because of this, a subtract with register 0 as the minuend is a negate, and a conditional jump on register 0 is always taken, which gives a halt instruction. Register 7 is the display register. Its low three bits and its sign bit leave the block on separate pins. Two flag bits report the zero and overflow state of the most recent add or subtract. When no halting jump runs, the program counter wraps from the last address to the first and the program repeats.

Instruction word layout: bits [11:10] hold the operation, [9:7] the destination/first register `ra`, [6:4] the second register `rb`, and [3:0] the immediate. A jump takes its target from bits [2:0].

Top module: `nano_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, all registers and both flags are cleared. All outputs therefore read zero in the following cycle.
- R2: Register 0 always reads as zero. Any write aimed at it, such as a move with `ra`=0, leaves no trace at the outputs.
- R3: Operation 2'b00 (add) writes `ra` <= `ra` + `rb`, modulo 16.
- R4: Operation 2'b01 (subtract) writes `ra` <= `rb` - `ra`, modulo 16. With `rb`=0 this negates `ra`.
- R5: Operation 2'b10 (move) writes `ra` <= immediate bits [3:0].
- R6: Operation 2'b11 (jump-if-zero) sets the program counter to bits [2:0] when register `ra` reads zero, and to the next address otherwise. Every other operation advances the counter by one. The counter wraps from 7 to 0.
- R7: An add or subtract sets `flag_zero` when its 4-bit result is zero, and sets `flag_ovf` when the signed two's-complement result falls outside -8..7. Moves and jumps leave both flags unchanged. Flags change on the same edge as the register write.
- R8: `disp_lo` equals register 7 bits [2:0] and `disp_sign` equals register 7 bit 3, at all times.
- R9: With the default program, the core halts on address 7, showing `disp_lo`=6 and `disp_sign`=0, with both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock, one instruction per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| disp_lo | output | 3 | Low three bits of the display register |
| disp_sign | output | 1 | Sign bit of the display register |
| flag_zero | output | 1 | Zero flag from the last add or subtract |
| flag_ovf | output | 1 | Signed overflow flag from the last add or subtract |

## Verification
Only the display register and the two flags are visible at the ports. A wrong register value or a misrouted operand therefore stays hidden until it flows into register 7 through an add or subtract, or until it steers a conditional jump. Flag errors, in contrast, show up on the edge right after the faulty arithmetic instruction. The bench runs a reference model alongside the design on every clock, using two programs. The second program negates, subtracts into overflow, writes into register 0, and wraps through the counter twice. This routes every operand path into the display within a few cycles and makes the second pass depend on the state left by the first pass.

// File: rtl/nano_pkg.sv
package nano_pkg;

    localparam int DATA_W    = 4;
    localparam int RSEL_W    = 3;
    localparam int PC_W      = 3;
    localparam int IMM_W     = 4;
    localparam int INSTR_W   = 2 + 2 * RSEL_W + IMM_W;
    localparam int ROM_DEPTH = 1 << PC_W;
    localparam int REG_N     = 1 << RSEL_W;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MOV = 2'b10,
        OP_JZR = 2'b11
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [RSEL_W-1:0] ra;
        logic [RSEL_W-1:0] rb;
        logic [IMM_W-1:0]  imm;
    } instr_t;

    typedef struct packed {
        logic reg_we;
        logic arith;
        logic do_sub;
        logic take_imm;
        logic cond_jump;
    } ctrl_t;

    // Default program: sum 1..3 into R1, copy to R7, park on address 7.
    localparam logic [ROM_DEPTH*INSTR_W-1:0] SUM_PROG = {
        12'b110000000111,   // 7: jump-if-zero R0 -> 7 (halt)
        12'b001110010000,   // 6: R7 += R1
        12'b000010110000,   // 5: R1 += R3
        12'b000010100000,   // 4: R1 += R2
        12'b100110000011,   // 3: R3 = 3
        12'b100100000010,   // 2: R2 = 2
        12'b100010000001,   // 1: R1 = 1
        12'b100000000000    // 0: filler, write to R0
    };

    function automatic ctrl_t decode(input instr_t ins);
        ctrl_t c;
        c.reg_we    = (ins.op != OP_JZR);
        c.arith     = (ins.op == OP_ADD) || (ins.op == OP_SUB);
        c.do_sub    = (ins.op == OP_SUB);
        c.take_imm  = (ins.op == OP_MOV);
        c.cond_jump = (ins.op == OP_JZR);
        return c;
    endfunction

endpackage

// File: rtl/nano_pc.sv
module nano_pc
    import nano_pkg::*;
#(
    parameter int AW = PC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] target,
    output logic [AW-1:0] pc
);

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (load)
            pc <= target;
        else
            pc <= pc + AW'(1);
    end

endmodule

// File: rtl/nano_regfile.sv
module nano_regfile
    import nano_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int SW = RSEL_W,
    localparam int NREG = 1 << SW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [SW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [SW-1:0] raddr_a,
    input  logic [SW-1:0] raddr_b,
    output logic [DW-1:0] rdata_a,
    output logic [DW-1:0] rdata_b,
    output logic [DW-1:0] disp_q
);

    logic [DW-1:0] q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) q[i] <= '0;
        end else if (we && (waddr != '0)) begin
            q[waddr] <= wdata;
        end
    end

    // Register 0 is a ground: reads are forced to zero.
    assign rdata_a = (raddr_a == '0) ? '0 : q[raddr_a];
    assign rdata_b = (raddr_b == '0) ? '0 : q[raddr_b];
    assign disp_q  = q[NREG-1];

    assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr != '0)) |=> (q[$past(waddr)] == $past(wdata)));

    assert_ground_read_R2: assert property (@(posedge clk) disable iff (rst)
        (raddr_a == '0) |-> (rdata_a == '0));

endmodule

// File: rtl/nano_addsub.sv
module nano_addsub
    import nano_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sub,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic [DW-1:0] res,
    output logic          zero_q,
    output logic          ovf_q
);

    logic [DW-1:0] y_eff;
    logic          ovf_now;

    assign y_eff   = sub ? ~y : y;
    assign res     = x + y_eff + DW'(sub);
    assign ovf_now = (x[DW-1] == y_eff[DW-1]) && (res[DW-1] != x[DW-1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_q <= 1'b0;
            ovf_q  <= 1'b0;
        end else if (en) begin
            zero_q <= (res == '0);
            ovf_q  <= ovf_now;
        end
    end

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(zero_q) && $stable(ovf_q)));

    assert_zero_tracks_R7: assert property (@(posedge clk) disable iff (rst)
        (en && (x == y) && sub) |=> zero_q);

endmodule

// File: rtl/nano_core.sv
module nano_core
    import nano_pkg::*;
#(
    parameter logic [ROM_DEPTH*INSTR_W-1:0] PROG = SUM_PROG
) (
    input  logic       clk,
    input  logic       rst,
    output logic [2:0] disp_lo,
    output logic       disp_sign,
    output logic       flag_zero,
    output logic       flag_ovf
);

    logic [PC_W-1:0]   pc;
    instr_t            ins;
    ctrl_t             ctl;
    logic [DATA_W-1:0] va, vb, alu_x, alu_y, alu_res, wdata, disp_q;
    logic              jump;

    // Fetch and decode.
    assign ins = instr_t'(PROG[pc*INSTR_W +: INSTR_W]);
    assign ctl = decode(ins);

    nano_regfile #(.DW(DATA_W), .SW(RSEL_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl.reg_we),
        .waddr   (ins.ra),
        .wdata   (wdata),
        .raddr_a (ins.ra),
        .raddr_b (ins.rb),
        .rdata_a (va),
        .rdata_b (vb),
        .disp_q  (disp_q)
    );

    // Subtract computes rb - ra, so its operands swap.
    assign alu_x = ctl.do_sub ? vb : va;
    assign alu_y = ctl.do_sub ? va : vb;

    nano_addsub #(.DW(DATA_W)) u_alu (
        .clk    (clk),
        .rst    (rst),
        .en     (ctl.arith),
        .sub    (ctl.do_sub),
        .x      (alu_x),
        .y      (alu_y),
        .res    (alu_res),
        .zero_q (flag_zero),
        .ovf_q  (flag_ovf)
    );

    assign wdata = ctl.take_imm ? ins.imm : alu_res;
    assign jump  = ctl.cond_jump && (va == '0);

    nano_pc #(.AW(PC_W)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .load   (jump),
        .target (ins.imm[PC_W-1:0]),
        .pc     (pc)
    );

    assign disp_lo   = disp_q[2:0];
    assign disp_sign = disp_q[DATA_W-1];

    assert_pc_step_R6: assert property (@(posedge clk) disable iff (rst)
        (ins.op != OP_JZR) |=> (pc == $past(pc) + PC_W'(1)));

    assert_jump_taken_R6: assert property (@(posedge clk) disable iff (rst)
        ((ins.op == OP_JZR) && (va == '0)) |=> (pc == $past(ins.imm[PC_W-1:0])));

    assert_display_steady_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctl.reg_we || (ins.ra != 3'd7)) |=> $stable({disp_sign, disp_lo}));

endmodule

// File: tb/test_nano_core.sv
module test_nano_core;
    import nano_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    localparam logic [ROM_DEPTH*INSTR_W-1:0] PROG_B = {
        12'b001110000000,   // 7: R7 += R0
        12'b110010000000,   // 6: jump-if-zero R1 -> 0
        12'b100000000111,   // 5: R0 = 7 (discarded)
        12'b001110010000,   // 4: R7 += R1
        12'b010010100000,   // 3: R1 = R2 - R1
        12'b010010000000,   // 2: R1 = -R1
        12'b100100000011,   // 1: R2 = 3
        12'b100010000101    // 0: R1 = 5
    };

    logic [2:0] lo   [2];
    logic       sgn  [2];
    logic       zf   [2];
    logic       of   [2];

    nano_core i_nano_core (
        .clk(clk), .rst(rst), .disp_lo(lo[0]), .disp_sign(sgn[0]),
        .flag_zero(zf[0]), .flag_ovf(of[0]));

    nano_core #(.PROG(PROG_B)) i_nano_core_alt (
        .clk(clk), .rst(rst), .disp_lo(lo[1]), .disp_sign(sgn[1]),
        .flag_zero(zf[1]), .flag_ovf(of[1]));

    int    vectors = 0;
    int    miscompares = 0;
    int    mreg [2][8];
    int    mpc  [2];
    bit    mz   [2];
    bit    mo   [2];
    string mtag [2];

    function automatic int sx(input int v);
        return (v >= 8) ? v - 16 : v;
    endfunction

    function automatic logic [11:0] fetch(input int k, input int a);
        return (k == 0) ? SUM_PROG[a*12 +: 12] : PROG_B[a*12 +: 12];
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            for (int r = 0; r < 8; r++) mreg[k][r] = 0;
            mpc[k] = 0; mz[k] = 0; mo[k] = 0; mtag[k] = "R1";
        end
    endtask

    task automatic model_step(input int k);
        logic [11:0] w;
        int op, a, b, imm, va, vb, s;
        w   = fetch(k, mpc[k]);
        op  = int'(w[11:10]);
        a   = int'(w[9:7]);
        b   = int'(w[6:4]);
        imm = int'(w[3:0]);
        va  = (a == 0) ? 0 : mreg[k][a];
        vb  = (b == 0) ? 0 : mreg[k][b];
        if (op == 3) begin
            mtag[k] = "R6";
            mpc[k]  = (va == 0) ? (imm % 8) : (mpc[k] + 1) % 8;
        end else begin
            if (op == 2) begin
                s = imm;
                mtag[k] = (a == 0) ? "R2" : "R5";
            end else begin
                s = (op == 0) ? sx(va) + sx(vb) : sx(vb) - sx(va);
                mo[k] = (s > 7) || (s < -8);
                s = s & 15;
                mz[k] = (s == 0);
                mtag[k] = (op == 0) ? "R3" : "R4";
            end
            if (a != 0) mreg[k][a] = s & 15;
            mpc[k] = (mpc[k] + 1) % 8;
        end
    endtask

    task automatic compare(input int k);
        int exp_d, got_d;
        exp_d = mreg[k][7];
        got_d = {28'd0, sgn[k], lo[k]};
        vectors++;
        if (got_d != exp_d) begin
            miscompares++;
            $display("FAIL R8 %s inst%0d display: got %0d expected %0d", mtag[k], k, got_d, exp_d);
        end
        vectors++;
        if ({zf[k], of[k]} != {mz[k], mo[k]}) begin
            miscompares++;
            $display("FAIL R7 %s inst%0d flags z/o: got %0b%0b expected %0b%0b",
                     mtag[k], k, zf[k], of[k], mz[k], mo[k]);
        end
    endtask

    task automatic run(input int n);
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            model_step(0);
            model_step(1);
            @(negedge clk);
            compare(0);
            compare(1);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        model_reset();
        // R1: reset state on all outputs
        repeat (3) begin
            @(negedge clk);
            compare(0);
            compare(1);
        end
        rst = 1'b0;
        run(40);

        // R9: default program parked showing 6, flags clear
        vectors++;
        if ({sgn[0], lo[0], zf[0], of[0]} != 6'b0110_00) begin
            miscompares++;
            $display("FAIL R9 final state: got %b expected 011000",
                     {sgn[0], lo[0], zf[0], of[0]});
        end

        // R1: reset again in the middle of activity
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        compare(0);
        compare(1);
        rst = 1'b0;
        run(12);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule